// File: doc/BRIEF.md
# Eight-Pin Masked-Access GPIO Bank with Interrupt Detection

This block is one bank of eight general-purpose pins behind a simple memory-mapped register bus with byte-wide data. Each pin has a direction bit and an output latch. Each pin also has an input value, taken through a two-stage synchronizer. The pin-state and direction registers are reached through a range of addresses. The word-address bits 9..2 of each access form a per-pin mask, so software can set, clear or read any subset of pins in one access, without a read-modify-write sequence.

Each pin can raise an interrupt. The pin can be set to sense a level or an edge, and either polarity. In edge mode it can also trigger on any transition. Edge events stay latched until software acknowledges them by writing ones. A level condition is reported live. An enable register gates the raw status into a masked status, and the OR of the masked bits drives a single interrupt line. A per-pin alternate-function select hands a pad over to an on-chip peripheral. When set, the pad's drive value and output enable come from the peripheral. Banks repeat every 0x1000 bytes in a larger map; this block decodes one bank only.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every register is zero. All pads are inputs (pad_oe = 0x00), reads of the direction, raw status and masked status return 0x00, and irq is low.
- R2: A write with byte address bits [11:10] = 00 (byte addresses 0x000..0x3FC) updates the output latch only in the pins whose mask bit is 1. Mask bit n is byte-address bit n+2. The other pins keep their value.
- R3: A write with byte address bits [11:10] = 10 (0x800..0xBFC) updates the direction bits in the same masked way. A direction bit of 1 makes the pin an output. With its alternate-function bit at 0, a pin drives pad_oe from its direction bit and pad_out from its output latch.
- R4: A read in the pin-state or direction range returns the value in the pins whose mask bit is 1, and 0 in the other bit positions. For the pin-state value, an output pin shows its output latch and an input pin shows its synchronized input.
- R5: A change on pin_in shows on periph_in, and in pin-state reads, after exactly two rising clock edges.
- R6: A pin with its mode bit (0x404) at 1 uses level sensing. Its raw status is the synchronized input when its polarity bit (0x40C) is 1, and the inverted input when the polarity bit is 0. Writing the acknowledge register does not change it.
- R7: A pin with mode 0 and its any-edge bit (0x408) at 0 latches a raw status bit on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. The bit stays set until acknowledged. The opposite edge does not set it.
- R8: A pin with mode 0 and any-edge 1 latches on both rising and falling edges, whatever its polarity bit.
- R9: Writing 1 to a bit of the write-only acknowledge register (0x41C) clears that latched edge bit. Writing 0 leaves it set. Reads of 0x41C return 0.
- R10: Raw status reads at 0x414. Masked status reads at 0x418 and equals raw status AND the enable register (0x410). irq is high exactly when any masked status bit is 1.
- R11: A pin whose alternate-function bit (0x420) is 1 drives pad_out from periph_out and pad_oe from periph_oe, instead of its own registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe for this bank |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte-address bits 11..2 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a selected read |
| pin_in | input | 8 | Asynchronous pad input values |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad output enables |
| periph_out | input | 8 | Peripheral drive values for alternate function |
| periph_oe | input | 8 | Peripheral output enables for alternate function |
| periph_in | output | 8 | Synchronized pad inputs to peripherals |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench mixes random masked writes and reads with random pin patterns. A design that ignored the address mask, or took it from the wrong bits, would change or report pins outside the selected set. The synchronizer latency is checked one edge early and on the expected edge, so a one-stage or three-stage path shows up. The edge tests check the opposite edge, both edges with each polarity, and acknowledge writes with mixed ones and zeros. A swapped polarity, an any-edge bit that fails to override polarity, or an acknowledge that clears on zero would all leave a wrong raw status bit. Level-mode pins are acknowledged and must keep reporting, which catches a design that latches levels.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int unsigned PB_PINS = 8;
    localparam int unsigned PB_AW   = 12;

    localparam logic [PB_AW-1:0] OFS_MODE    = 12'h404;
    localparam logic [PB_AW-1:0] OFS_ANYEDGE = 12'h408;
    localparam logic [PB_AW-1:0] OFS_POL     = 12'h40C;
    localparam logic [PB_AW-1:0] OFS_ENABLE  = 12'h410;
    localparam logic [PB_AW-1:0] OFS_RAW     = 12'h414;
    localparam logic [PB_AW-1:0] OFS_MASKED  = 12'h418;
    localparam logic [PB_AW-1:0] OFS_ACK     = 12'h41C;
    localparam logic [PB_AW-1:0] OFS_ALTFN   = 12'h420;

    typedef logic [PB_PINS-1:0] pinvec_t;

    typedef enum logic [1:0] {
        REGION_DATA = 2'b00,
        REGION_CTRL = 2'b01,
        REGION_DIR  = 2'b10,
        REGION_NONE = 2'b11
    } region_e;

    typedef struct packed {
        pinvec_t dout;
        pinvec_t dir;
        pinvec_t mode;
        pinvec_t anyedge;
        pinvec_t polarity;
        pinvec_t enable;
        pinvec_t altfn;
    } cfg_t;

    typedef struct packed {
        pinvec_t prev;
        pinvec_t latch;
    } det_t;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [PB_AW-1:2] addr,
    input  pinvec_t    wdata,
    output cfg_t       cfg,
    output pinvec_t    wmask,
    output logic       data_wr,
    output logic       dir_wr,
    output pinvec_t    ack_mask
);

    localparam int unsigned MASK_HI = PB_PINS + 1;

    cfg_t    cfg_d, cfg_q;
    region_e region;

    assign region  = region_e'(addr[PB_AW-1:PB_AW-2]);
    assign wmask   = addr[MASK_HI:2];
    assign data_wr = wr_en && (region == REGION_DATA);
    assign dir_wr  = wr_en && (region == REGION_DIR);
    assign ack_mask = (wr_en && addr == OFS_ACK[PB_AW-1:2]) ? wdata : '0;

    always_comb begin
        cfg_d = cfg_q;
        if (data_wr) begin
            cfg_d.dout = (cfg_q.dout & ~wmask) | (wdata & wmask);
        end
        if (dir_wr) begin
            cfg_d.dir = (cfg_q.dir & ~wmask) | (wdata & wmask);
        end
        if (wr_en && region == REGION_CTRL) begin
            if (addr == OFS_MODE[PB_AW-1:2])    cfg_d.mode     = wdata;
            if (addr == OFS_ANYEDGE[PB_AW-1:2]) cfg_d.anyedge  = wdata;
            if (addr == OFS_POL[PB_AW-1:2])     cfg_d.polarity = wdata;
            if (addr == OFS_ENABLE[PB_AW-1:2])  cfg_d.enable   = wdata;
            if (addr == OFS_ALTFN[PB_AW-1:2])   cfg_d.altfn    = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
    import pinbank_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pinvec_t sync_in,
    input  pinvec_t mode,
    input  pinvec_t anyedge,
    input  pinvec_t polarity,
    input  pinvec_t ack_mask,
    output pinvec_t raw
);

    det_t    det_d, det_q;
    pinvec_t rise, fall, hit, level;

    always_comb begin
        rise  = sync_in & ~det_q.prev;
        fall  = ~sync_in & det_q.prev;
        hit   = ~mode & ((anyedge & (rise | fall))
                       | (~anyedge & polarity & rise)
                       | (~anyedge & ~polarity & fall));
        level = (polarity & sync_in) | (~polarity & ~sync_in);
        det_d.prev  = sync_in;
        det_d.latch = (det_q.latch & ~ack_mask) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    generate
        for (genvar p = 0; p < PB_PINS; p++) begin : g_raw
            assign raw[p] = mode[p] ? level[p] : det_q.latch[p];
        end
    endgenerate

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [PB_AW-1:2]  bus_addr,
    input  logic [PB_PINS-1:0] bus_wdata,
    output logic [PB_PINS-1:0] bus_rdata,
    input  logic [PB_PINS-1:0] pin_in,
    output logic [PB_PINS-1:0] pad_out,
    output logic [PB_PINS-1:0] pad_oe,
    input  logic [PB_PINS-1:0] periph_out,
    input  logic [PB_PINS-1:0] periph_oe,
    output logic [PB_PINS-1:0] periph_in,
    output logic              irq
);

    cfg_t    cfg;
    pinvec_t wmask, ack_mask, sync_in, raw_st, masked_st, pin_val;
    logic    data_wr, dir_wr;
    region_e rd_region;

    pinbank_sync #(.WIDTH(PB_PINS), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_in)
    );

    pinbank_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_sel && bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cfg      (cfg),
        .wmask    (wmask),
        .data_wr  (data_wr),
        .dir_wr   (dir_wr),
        .ack_mask (ack_mask)
    );

    pinbank_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .mode     (cfg.mode),
        .anyedge  (cfg.anyedge),
        .polarity (cfg.polarity),
        .ack_mask (ack_mask),
        .raw      (raw_st)
    );

    assign masked_st = raw_st & cfg.enable;
    assign pin_val   = (cfg.dir & cfg.dout) | (~cfg.dir & sync_in);
    assign rd_region = region_e'(bus_addr[PB_AW-1:PB_AW-2]);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            unique case (rd_region)
                REGION_DATA: bus_rdata = pin_val & wmask;
                REGION_DIR:  bus_rdata = cfg.dir & wmask;
                REGION_CTRL: begin
                    if (bus_addr == OFS_MODE[PB_AW-1:2])    bus_rdata = cfg.mode;
                    if (bus_addr == OFS_ANYEDGE[PB_AW-1:2]) bus_rdata = cfg.anyedge;
                    if (bus_addr == OFS_POL[PB_AW-1:2])     bus_rdata = cfg.polarity;
                    if (bus_addr == OFS_ENABLE[PB_AW-1:2])  bus_rdata = cfg.enable;
                    if (bus_addr == OFS_RAW[PB_AW-1:2])     bus_rdata = raw_st;
                    if (bus_addr == OFS_MASKED[PB_AW-1:2])  bus_rdata = masked_st;
                    if (bus_addr == OFS_ALTFN[PB_AW-1:2])   bus_rdata = cfg.altfn;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    generate
        for (genvar p = 0; p < PB_PINS; p++) begin : g_pad
            assign pad_out[p] = cfg.altfn[p] ? periph_out[p] : cfg.dout[p];
            assign pad_oe[p]  = cfg.altfn[p] ? periph_oe[p]  : cfg.dir[p];
        end
    endgenerate

    assign periph_in = sync_in;
    assign irq       = |masked_st;

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
    import pinbank_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    irq,
    input pinvec_t en,
    input pinvec_t dout,
    input pinvec_t dir,
    input pinvec_t sense,
    input pinvec_t raw,
    input pinvec_t sync,
    input pinvec_t mask,
    input pinvec_t wdata,
    input logic    data_wr,
    input logic    dir_wr
);

    assert_quiet_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

    assert_data_unmasked_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (((dout ^ $past(dout)) & ~$past(mask)) == '0));

    assert_dir_masked_written_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (((dir ^ $past(wdata)) & $past(mask)) == '0));

    assert_edge_needs_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & ~$past(raw) & ~sense & ~$past(sense)
          & ~($past(sync) ^ $past(sync, 2))) == '0));

endmodule

bind pinbank_ctrl pinbank_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .en      (cfg.enable),
    .dout    (cfg.dout),
    .dir     (cfg.dir),
    .sense   (cfg.mode),
    .raw     (raw_st),
    .sync    (sync_in),
    .mask    (wmask),
    .wdata   (bus_wdata),
    .data_wr (data_wr),
    .dir_wr  (dir_wr)
);

// File: tb/test_pinbank_ctrl.sv
module test_pinbank_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] pin_in = '0, pad_out, pad_oe, periph_out = '0, periph_oe = '0, periph_in;
    logic       irq;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_dout = 0, m_dir = 0, m_mode = 0, m_any = 0, m_pol = 0;
    logic [7:0] m_en = 0, m_alt = 0, m_latch = 0, m_pins = 0;

    always #10 clk = ~clk;

    pinbank_ctrl i_pinbank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we),
        .bus_addr(addr[11:2]), .bus_wdata(wdata), .bus_rdata(rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1; we = 0; addr = a;
        #2 d = rdata;
        sel = 0;
    endtask

    function automatic logic [7:0] edge_hit(input logic [7:0] o, input logic [7:0] n);
        logic [7:0] r, f;
        r = n & ~o;
        f = o & ~n;
        return ~m_mode & ((m_any & (r | f)) | (~m_any & m_pol & r) | (~m_any & ~m_pol & f));
    endfunction

    function automatic logic [7:0] raw_exp();
        return (m_mode & ((m_pol & m_pins) | (~m_pol & ~m_pins))) | (~m_mode & m_latch);
    endfunction

    function automatic logic [7:0] mask_of(input logic [11:0] a);
        return a[9:2];
    endfunction

    task automatic set_pins(input logic [7:0] v);
        m_latch = m_latch | edge_hit(m_pins, v);
        @(negedge clk);
        pin_in = v;
        m_pins = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_status(input string req);
        logic [7:0] r;
        rd(12'h414, r); chk({req, " raw"}, r, raw_exp());
        rd(12'h418, r); chk({req, " masked R10"}, r, raw_exp() & m_en);
        chk({req, " irq R10"}, {7'd0, irq}, {7'd0, |(raw_exp() & m_en)});
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] r, v, a;
        logic [11:0] ad;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(12'h3FC, r); chk("R1 data", r, 8'h00);
        rd(12'hBFC, r); chk("R1 dir", r, 8'h00);
        rd(12'h414, r); chk("R1 raw", r, 8'h00);
        rd(12'h418, r); chk("R1 masked", r, 8'h00);
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R2 R3 R4 random masked access
        for (int it = 0; it < 60; it++) begin
            if (it % 6 == 0) set_pins(8'($urandom));
            v  = 8'($urandom);
            ad = {2'b00, 8'($urandom), 2'b00};
            if ($urandom % 2) begin
                ad[11] = 1'b1;
                wr(ad, v);
                m_dir = (m_dir & ~mask_of(ad)) | (v & mask_of(ad));
            end else begin
                wr(ad, v);
                m_dout = (m_dout & ~mask_of(ad)) | (v & mask_of(ad));
            end
            ad = {2'b00, 8'($urandom), 2'b00};
            rd(ad, r);
            chk("R4 data read", r, ((m_dir & m_dout) | (~m_dir & m_pins)) & mask_of(ad));
            ad[11] = 1'b1;
            rd(ad, r);
            chk("R4 dir read", r, m_dir & mask_of(ad));
            chk("R2 pad_out", pad_out, m_dout);
            chk("R3 pad_oe", pad_oe, m_dir);
        end
        // R2 directed: single-pin write leaves others
        wr(12'h3FC, 8'hA5); m_dout = 8'hA5;
        wr(12'h010, 8'hFF); m_dout[2] = 1'b1;
        chk("R2 single pin", pad_out, 8'hA5 | 8'h04);
        wr(12'h000, 8'h00);
        chk("R2 zero mask", pad_out, m_dout);

        // R5 synchronizer latency
        wr(12'hBFC, 8'h00); m_dir = 8'h00;
        v = m_pins ^ 8'h01;
        m_latch = m_latch | edge_hit(m_pins, v);
        @(negedge clk); pin_in = v;
        @(negedge clk); chk("R5 one edge", periph_in, m_pins);
        @(negedge clk); chk("R5 two edges", periph_in, v);
        m_pins = v;
        repeat (3) @(negedge clk);

        // R11 alternate function
        wr(12'h420, 8'hF0); m_alt = 8'hF0;
        for (int it = 0; it < 4; it++) begin
            @(negedge clk);
            periph_out = 8'($urandom); periph_oe = 8'($urandom);
            #2;
            chk("R11 pad_out", pad_out, (m_alt & periph_out) | (~m_alt & m_dout));
            chk("R11 pad_oe", pad_oe, (m_alt & periph_oe) | (~m_alt & m_dir));
        end
        wr(12'h420, 8'h00); m_alt = 8'h00;

        // R7 R8 R9 R10 edge detection
        wr(12'h41C, 8'hFF); m_latch = 8'h00;
        check_status("R9 clear all");
        wr(12'h404, 8'h00); m_mode = 8'h00;
        for (int it = 0; it < 40; it++) begin
            m_any = 8'($urandom); m_pol = 8'($urandom); m_en = 8'($urandom);
            wr(12'h408, m_any); wr(12'h40C, m_pol); wr(12'h410, m_en);
            set_pins(8'($urandom));
            check_status("R7 R8 edge");
            if (it % 3 == 2) begin
                a = 8'($urandom);
                wr(12'h41C, a); m_latch = m_latch & ~a;
                check_status("R9 partial ack");
            end
        end
        // directed: both edges with polarity 1 catch a falling edge (R8)
        set_pins(8'hFF);
        wr(12'h41C, 8'hFF); m_latch = 8'h00;
        m_any = 8'h01; m_pol = 8'h03; m_en = 8'hFF;
        wr(12'h408, m_any); wr(12'h40C, m_pol); wr(12'h410, m_en);
        set_pins(8'h00);
        rd(12'h414, r); chk("R8 fall with any-edge, R7 opposite edge ignored", r, 8'hFD);
        wr(12'h41C, 8'h00);
        rd(12'h414, r); chk("R9 zero write no effect", r, 8'hFD);
        rd(12'h41C, r); chk("R9 ack reads zero", r, 8'h00);
        wr(12'h410, 8'h00); m_en = 8'h00;
        chk("R10 irq gated", {7'd0, irq}, 8'h00);

        // R6 level mode
        wr(12'h41C, 8'hFF); m_latch = 8'h00;
        m_mode = 8'hFF; wr(12'h404, m_mode);
        for (int it = 0; it < 12; it++) begin
            m_pol = 8'($urandom); m_en = 8'($urandom);
            wr(12'h40C, m_pol); wr(12'h410, m_en);
            set_pins(8'($urandom));
            check_status("R6 level");
            wr(12'h41C, 8'hFF);
            rd(12'h414, r); chk("R6 ack ignored", r, raw_exp());
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule